// File: doc/BRIEF.md
# Tagged Two-Channel Link Multiplexer

This block lets several independent producer channels (two by default) share one downstream data link. Each channel has its own valid/ready input and its own ack pulse output. A word accepted from a channel is forwarded on the shared link together with a tag that holds the index of the channel it came from. The far end returns acknowledgements on one shared upstream port, and each ack carries a tag. The block delivers each ack only to the channel that the tag names.

Flow control is stop-and-wait. Each channel controller steps through three phases: idle, where it can accept a word; send, where the word is offered to the link; and wait, where it waits for its own ack. A channel therefore has at most one word in flight. When several channels offer a word at the same time, a round-robin arbiter decides the order. The forwarded word sits in an output register that stays stable until the link takes it.

An ack whose tag names no channel that is waiting is dropped, and it raises a sticky error flag. Adding a channel adds one controller, one more arbiter and multiplexer input, and one more ack output.

Top module: `tagged_link_mux`

## Requirements
- R1: Every word on the link carries its payload on `dn_data` and the index of its source channel on `dn_tag` (channel 0 gives tag 0, channel 1 gives tag 1).
- R2: After synchronous active-high reset, every `in_ready` bit is 1, and `dn_valid`, `ack_out` and `ack_err` are 0. Reset also clears the arbiter pointer, so channel 0 wins the first tie.
- R3: Once a channel accepts a word (`in_valid` and `in_ready` both high at a clock edge), its `in_ready` stays 0 until the clock edge at which its ack is delivered.
- R4: A word accepted at clock edge k is presented with `dn_valid` high after edge k+1, provided the link register is free.
- R5: `ack_out[i]` is high in the same cycle as `up_ack_valid` when `up_ack_tag` equals i and channel i is waiting for its ack. All other `ack_out` bits stay 0.
- R6: While `dn_valid` is high and `dn_ready` is low, `dn_valid`, `dn_data` and `dn_tag` hold their values on the next cycle.
- R7: An ack whose tag names a channel that is not waiting produces no `ack_out` pulse. It sets `ack_err` at the next edge, and `ack_err` stays 1 until reset.
- R8: When several channels offer a word at once, the grant goes to the first offering channel at or after the pointer. After each grant the pointer moves to the channel that follows the granted one.
- R9: A channel that is waiting for its ack does not block another channel from accepting, forwarding, or receiving its own ack.
- R10: `N_CH` must be at least 2 and `DATA_W` at least 1. The tag width is ceil(log2(`N_CH`)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_CH | Per-channel word offered |
| in_data | input | N_CH*DATA_W | Per-channel payloads; channel i occupies bits [i*DATA_W +: DATA_W] |
| in_ready | output | N_CH | Per-channel accept (high only in the idle phase) |
| ack_out | output | N_CH | Per-channel ack pulse |
| dn_valid | output | 1 | Link word valid |
| dn_data | output | DATA_W | Link payload |
| dn_tag | output | TAG_W | Link channel tag |
| dn_ready | input | 1 | Link accepts the word |
| up_ack_valid | input | 1 | Returning ack present |
| up_ack_tag | input | TAG_W | Channel tag of the returning ack |
| ack_err | output | 1 | Sticky flag for a stray ack |

## Verification
Ack delivery to one channel can fall in the same cycle as the link handoff of another channel's word. The bench provokes this by holding channel 0 in its wait phase while channel 1 offers a word. It then returns channel 0's ack during the cycle in which channel 1's word is on the link. The check passes when the tag and payload on the link are channel 1's, only `ack_out[0]` pulses, and on the next cycle channel 0 is ready again while channel 1 is still blocked.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SEND = 2'd1,
      PH_WAIT = 2'd2
   } phase_t;

   function automatic int tag_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tlm_chan_ctrl.sv
module tlm_chan_ctrl
   import tlm_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              req,
   output logic [DATA_W-1:0] word,
   input  logic              take,
   input  logic              ack_hit,
   output logic              waiting
);
   phase_t            phase_q;
   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         word_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (in_valid) begin
               word_q  <= in_data;
               phase_q <= PH_SEND;
            end
            PH_SEND: if (take)    phase_q <= PH_WAIT;
            PH_WAIT: if (ack_hit) phase_q <= PH_IDLE;
            default:              phase_q <= PH_IDLE;
         endcase
      end
   end

   assign in_ready = (phase_q == PH_IDLE);
   assign req      = (phase_q == PH_SEND);
   assign waiting  = (phase_q == PH_WAIT);
   assign word     = word_q;

   // R3: an accepted word closes the input until its ack is delivered
   a_r3_closed_after_accept: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);
   // R4: an accepted word is offered to the link on the next cycle
   a_r4_offer_next: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> req);
   // R5: an ack is delivered only to a channel that has a word outstanding
   a_r5_ack_only_waiting: assert property (@(posedge clk) disable iff (rst)
      ack_hit |-> (!in_ready && !req));
endmodule

// File: rtl/tlm_rr_arb.sv
module tlm_rr_arb #(
   parameter int N_CH  = 2,
   parameter int TAG_W = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_CH-1:0]  req,
   input  logic             advance,
   output logic [N_CH-1:0]  grant,
   output logic [TAG_W-1:0] gidx
);
   logic [TAG_W-1:0] ptr_q;
   logic             found;

   always_comb begin
      grant = '0;
      gidx  = '0;
      found = 1'b0;
      for (int k = 0; k < N_CH; k++) begin
         int j;
         j = (int'(ptr_q) + k) % N_CH;
         if (!found && req[j]) begin
            found    = 1'b1;
            grant[j] = 1'b1;
            gidx     = TAG_W'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         ptr_q <= '0;
      else if (advance) begin
         if (int'(gidx) == N_CH - 1) ptr_q <= '0;
         else                        ptr_q <= gidx + 1'b1;
      end
   end

   // R8: any request produces exactly one grant, and only to a requester
   a_r8_one_grant: assert property (@(posedge clk) disable iff (rst)
      (|req) |-> ($onehot(grant) && ((grant & ~req) == '0)));
endmodule

// File: rtl/tlm_link_mux.sv
module tlm_link_mux #(
   parameter int N_CH   = 2,
   parameter int DATA_W = 8,
   parameter int TAG_W  = 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [N_CH-1:0]          req,
   input  logic [N_CH*DATA_W-1:0]   words,
   output logic [N_CH-1:0]          take,
   output logic                     dn_valid,
   output logic [DATA_W-1:0]        dn_data,
   output logic [TAG_W-1:0]         dn_tag,
   input  logic                     dn_ready
);
   logic [N_CH-1:0]   grant;
   logic [TAG_W-1:0]  gidx;
   logic              load;
   logic              v_q;
   logic [DATA_W-1:0] d_q;
   logic [TAG_W-1:0]  t_q;

   assign load = (|req) && (!v_q || dn_ready);
   assign take = grant & {N_CH{load}};

   tlm_rr_arb #(.N_CH(N_CH), .TAG_W(TAG_W)) arb_i (
      .clk(clk), .rst(rst), .req(req), .advance(load),
      .grant(grant), .gidx(gidx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q <= 1'b0;
         d_q <= '0;
         t_q <= '0;
      end else if (load) begin
         v_q <= 1'b1;
         d_q <= words[int'(gidx)*DATA_W +: DATA_W];
         t_q <= gidx;
      end else if (dn_ready) begin
         v_q <= 1'b0;
      end
   end

   assign dn_valid = v_q;
   assign dn_data  = d_q;
   assign dn_tag   = t_q;

   // R6: a stalled link word is held unchanged
   a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data) && $stable(dn_tag)));
endmodule

// File: rtl/tlm_ack_demux.sv
module tlm_ack_demux #(
   parameter int N_CH  = 2,
   parameter int TAG_W = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             up_ack_valid,
   input  logic [TAG_W-1:0] up_ack_tag,
   input  logic [N_CH-1:0]  waiting,
   output logic [N_CH-1:0]  hit,
   output logic             err
);
   logic err_q;

   always_comb begin
      for (int i = 0; i < N_CH; i++)
         hit[i] = up_ack_valid && (int'(up_ack_tag) == i) && waiting[i];
   end

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else if (up_ack_valid && !(|hit)) err_q <= 1'b1;
   end

   assign err = err_q;

   // R5: at most one channel receives an ack per cycle
   a_r5_ack_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit));
   // R7: the stray-ack flag is sticky
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
      err |=> err);
endmodule

// File: rtl/tagged_link_mux.sv
module tagged_link_mux
   import tlm_pkg::*;
#(
   parameter int N_CH   = 2,
   parameter int DATA_W = 8,
   localparam int TAG_W = tag_width(N_CH)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [N_CH-1:0]        in_valid,
   input  logic [N_CH*DATA_W-1:0] in_data,
   output logic [N_CH-1:0]        in_ready,
   output logic [N_CH-1:0]        ack_out,
   output logic                   dn_valid,
   output logic [DATA_W-1:0]      dn_data,
   output logic [TAG_W-1:0]       dn_tag,
   input  logic                   dn_ready,
   input  logic                   up_ack_valid,
   input  logic [TAG_W-1:0]       up_ack_tag,
   output logic                   ack_err
);
   // R10: elaboration-time parameter checks
   if (N_CH < 2)   begin : g_bad_n  $error("N_CH must be at least 2");   end
   if (DATA_W < 1) begin : g_bad_w  $error("DATA_W must be at least 1"); end

   logic [N_CH-1:0]        req;
   logic [N_CH-1:0]        take;
   logic [N_CH-1:0]        waiting;
   logic [N_CH-1:0]        hit;
   logic [N_CH*DATA_W-1:0] words;

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      tlm_chan_ctrl #(.DATA_W(DATA_W)) ctrl_i (
         .clk(clk), .rst(rst),
         .in_valid(in_valid[i]),
         .in_data(in_data[i*DATA_W +: DATA_W]),
         .in_ready(in_ready[i]),
         .req(req[i]),
         .word(words[i*DATA_W +: DATA_W]),
         .take(take[i]),
         .ack_hit(hit[i]),
         .waiting(waiting[i])
      );
   end

   tlm_link_mux #(.N_CH(N_CH), .DATA_W(DATA_W), .TAG_W(TAG_W)) mux_i (
      .clk(clk), .rst(rst), .req(req), .words(words), .take(take),
      .dn_valid(dn_valid), .dn_data(dn_data), .dn_tag(dn_tag), .dn_ready(dn_ready)
   );

   tlm_ack_demux #(.N_CH(N_CH), .TAG_W(TAG_W)) demux_i (
      .clk(clk), .rst(rst), .up_ack_valid(up_ack_valid), .up_ack_tag(up_ack_tag),
      .waiting(waiting), .hit(hit), .err(ack_err)
   );

   assign ack_out = hit;
endmodule

// File: tb/tagged_link_mux_tb_top.sv
module tagged_link_mux_tb_top;
   localparam int N = 2;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic [N-1:0] in_valid;
   logic [N*W-1:0] in_data;
   logic [N-1:0] in_ready, ack_out;
   logic         dn_valid, dn_ready, up_ack_valid, ack_err;
   logic [W-1:0] dn_data;
   logic [0:0]   dn_tag, up_ack_tag;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;  // 125 MHz

   tagged_link_mux #(.N_CH(N), .DATA_W(W)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .ack_out(ack_out), .dn_valid(dn_valid),
      .dn_data(dn_data), .dn_tag(dn_tag), .dn_ready(dn_ready),
      .up_ack_valid(up_ack_valid), .up_ack_tag(up_ack_tag), .ack_err(ack_err)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   task automatic offer(input int ch, input logic [W-1:0] d);
      @(negedge clk);
      in_valid[ch] = 1'b1;
      in_data[ch*W +: W] = d;
   endtask

   task automatic send_ack(input int ch, input logic [N-1:0] exp_hit, input string rq);
      @(negedge clk);
      up_ack_valid = 1'b1;
      up_ack_tag   = 1'(ch);
      #1 chk(ack_out == exp_hit, rq, 32'(ack_out), 32'(exp_hit));
      @(negedge clk);
      up_ack_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = '0; in_data = '0; dn_ready = 1'b1;
      up_ack_valid = 1'b0; up_ack_tag = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(in_ready == 2'b11, "R2 in_ready", 32'(in_ready), 32'h3);
      chk(!dn_valid && ack_out == 0 && !ack_err, "R2 outputs idle",
          {dn_valid, ack_out, ack_err}, 0);
   endtask

   // single word from channel ch: timing, tag, blocking, ack
   task automatic t_single(input int ch, input logic [W-1:0] d);
      offer(ch, d);
      chk(in_ready[ch], "R3 ready before accept", 32'(in_ready[ch]), 1);
      @(negedge clk);
      in_valid[ch] = 1'b0;
      chk(!in_ready[ch], "R3 closed after accept", 32'(in_ready[ch]), 0);
      chk(!dn_valid, "R4 not yet on link", 32'(dn_valid), 0);
      @(negedge clk);
      chk(dn_valid, "R4 on link next cycle", 32'(dn_valid), 1);
      chk(dn_data == d && int'(dn_tag) == ch, "R1 payload and tag",
          {dn_tag, dn_data}, {1'(ch), d});
      @(negedge clk);
      chk(!dn_valid, "R4 link drained", 32'(dn_valid), 0);
      chk(!in_ready[ch], "R3 still closed before ack", 32'(in_ready[ch]), 0);
      send_ack(ch, N'(1) << ch, "R5 ack steered");
      chk(in_ready[ch], "R3 reopened after ack", 32'(in_ready[ch]), 1);
   endtask

   // both offer at once after channel 0 was last granted: channel 1 first
   task automatic t_tie();
      t_single(0, 8'h11);
      @(negedge clk);
      in_valid = 2'b11; in_data = {8'hB1, 8'hB0};
      @(negedge clk);
      in_valid = 2'b00;
      @(negedge clk);
      chk(dn_valid && dn_tag == 1'b1 && dn_data == 8'hB1, "R8 rr picks ch1 first",
          {dn_tag, dn_data}, {1'b1, 8'hB1});
      @(negedge clk);
      chk(dn_valid && dn_tag == 1'b0 && dn_data == 8'hB0, "R8 ch0 follows",
          {dn_tag, dn_data}, {1'b0, 8'hB0});
      send_ack(1, 2'b10, "R5 ack ch1");
      send_ack(0, 2'b01, "R5 ack ch0");
      chk(in_ready == 2'b11, "R3 both reopened", 32'(in_ready), 3);
   endtask

   task automatic t_stall();
      dn_ready = 1'b0;
      offer(1, 8'h3C);
      @(negedge clk);
      in_valid[1] = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(dn_valid && dn_data == 8'h3C && dn_tag == 1'b1, "R6 held while stalled",
             {dn_valid, dn_tag, dn_data}, {1'b1, 1'b1, 8'h3C});
      end
      dn_ready = 1'b1;
      @(negedge clk);
      chk(!dn_valid, "R6 released on ready", 32'(dn_valid), 0);
      send_ack(1, 2'b10, "R5 ack after stall");
   endtask

   task automatic t_stray();
      send_ack(0, 2'b00, "R7 stray ack not delivered");
      chk(ack_err, "R7 err set", 32'(ack_err), 1);
      chk(in_ready == 2'b11, "R7 channels untouched", 32'(in_ready), 3);
      repeat (3) @(negedge clk);
      chk(ack_err, "R7 err sticky", 32'(ack_err), 1);
   endtask

   // ch0 waiting; ch1 forwarded; ch0 ack in same cycle as ch1 on link
   task automatic t_indep();
      offer(0, 8'h5A);
      @(negedge clk);
      in_valid[0] = 1'b0;
      @(negedge clk);
      chk(dn_tag == 1'b0 && dn_data == 8'h5A, "R1 ch0 word", {dn_tag, dn_data}, {1'b0, 8'h5A});
      in_valid[1] = 1'b1; in_data[W +: W] = 8'hC3;
      chk(in_ready[1], "R9 ch1 open while ch0 waits", 32'(in_ready[1]), 1);
      @(negedge clk);
      in_valid[1] = 1'b0;
      @(negedge clk);
      chk(dn_valid && dn_tag == 1'b1 && dn_data == 8'hC3, "R9 ch1 forwarded",
          {dn_tag, dn_data}, {1'b1, 8'hC3});
      up_ack_valid = 1'b1; up_ack_tag = 1'b0;
      #1 chk(ack_out == 2'b01, "R5 ack ch0 during ch1 handoff", 32'(ack_out), 1);
      @(negedge clk);
      up_ack_valid = 1'b0;
      chk(in_ready == 2'b01, "R9 ch0 open ch1 waiting", 32'(in_ready), 1);
      send_ack(1, 2'b10, "R5 ack ch1");
   endtask

   initial begin
      t_reset();
      t_single(0, 8'hA5);
      t_single(1, 8'h7E);
      t_tie();
      t_stall();
      t_indep();
      t_stray();
      t_reset();
      chk(!ack_err, "R2 reset clears err", 32'(ack_err), 0);
      t_single(0, 8'h01);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog act=0 exp=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule